// File: doc/BRIEF.md
# Burst Column Address Generator

This block stores a programmed mode word and, whenever a column command (read or write) is issued, produces the column address to use on each beat of the resulting burst. The burst can be 1, 2, 4 or 8 beats long, or it can cover a whole page. Its addresses follow one of two orders. In sequential order the low bits count upward and wrap inside an aligned block. In interleaved order the beat index is XORed into the low bits of the starting column.

A memory controller pulses `mode_load` to program the mode word. It pulses `cmd_start` with a starting column and a write flag to begin a burst. It pulses `cmd_stop` to cut a burst short. Each output beat is registered and appears one clock after the event that causes it. A new command is accepted on any clock and restarts the sequence at once. Each burst keeps the length and order that were in force when it started.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are 0. The stored mode word is all zeros, which selects a single-beat sequential burst for both reads and writes.
- R2: In the clock after `cmd_start` is sampled high, `col_valid` is 1 and `col_addr` equals the sampled `start_col`.
- R3: Mode bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8. A burst with no stop or restart presents exactly that many consecutive valid beats. `col_last` is high only on the final beat, and `col_valid` falls in the next clock.
- R4: When mode bit 3 is 0, beat k of an N-beat burst has address (start with its low log2(N) bits cleared) + ((start + k) mod N). For example, length 4 from column 1 gives 1,2,3,0.
- R5: When mode bit 3 is 1, beat k has the low log2(N) bits of the start XORed with k, and the upper bits are kept. For example, length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R6: Length code 111 selects full page. Beat k has address (start + k) mod 512, whatever the value of mode bit 3. `col_last` never rises, and the burst runs until a stop or a new command.
- R7: When mode bit 9 is 1, a burst started with `cmd_write`=1 lasts one beat and has `col_last`=1. A burst started with `cmd_write`=0 uses the programmed length.
- R8: A `cmd_stop` sampled high without `cmd_start` makes `col_valid` 0 in the next clock, for every burst length. If `cmd_start` is high in the same cycle, `cmd_start` wins.
- R9: A `cmd_start` sampled during a burst abandons that burst. The next clock presents beat 0 of the new burst.
- R10: The reserved length codes 100, 101 and 110 behave as length 1.
- R11: A `mode_load` takes effect only for commands sampled in later cycles. A burst already in progress keeps its length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Strobe that stores `mode_word` |
| mode_word | input | 13 | Mode: [2:0] length code, [3] interleave, [9] single-beat writes |
| cmd_start | input | 1 | Column command strobe; starts or restarts a burst |
| start_col | input | 9 | Starting column of the command |
| cmd_write | input | 1 | 1 when the command is a write |
| cmd_stop | input | 1 | Burst stop strobe |
| col_addr | output | 9 | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the last one of a finite burst |

## Verification
Some rules about the valid and last flags are checked by the assertions on every cycle. A start always yields a valid beat carrying the start column. A stop always clears valid. A last beat always ends the burst. A non-final beat always continues, and valid never rises by itself. The address order inside a burst depends on the stored mode and on the beat count, so only the bench's reference model can check it. That covers sequential and XOR wrapping from every start offset, full-page wrap past column 511, reserved length codes, the single-beat write option, and mode loads that arrive partway through a burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    // Burst length codes carried in the low field of the mode word
    typedef enum logic [2:0] {
        LEN_1  = 3'b000,
        LEN_2  = 3'b001,
        LEN_4  = 3'b010,
        LEN_8  = 3'b011,
        LEN_FP = 3'b111
    } len_code_e;

    // Field positions inside the mode word
    localparam int LEN_LSB   = 0;
    localparam int LEN_W     = 3;
    localparam int ORDER_BIT = 3;
    localparam int SWR_BIT   = 9;
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
    import bcg_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MODE_W = 13
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              is_write,
    output logic [COL_W-1:0]  wrap_mask,
    output logic              full_page,
    output logic              interleave
);
    logic [LEN_W-1:0] code;

    always_comb begin
        code       = mode[LEN_LSB +: LEN_W];
        full_page  = 1'b0;
        wrap_mask  = '0;
        unique case (code)
            LEN_2:   wrap_mask = COL_W'(1);
            LEN_4:   wrap_mask = COL_W'(3);
            LEN_8:   wrap_mask = COL_W'(7);
            LEN_FP: begin
                wrap_mask = '1;
                full_page = 1'b1;
            end
            default: wrap_mask = '0;   // length 1 and reserved codes
        endcase
        if (is_write && mode[SWR_BIT]) begin
            wrap_mask = '0;
            full_page = 1'b0;
        end
        // full page always runs in ascending order
        interleave = mode[ORDER_BIT] && !full_page;
    end
endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low;

    always_comb begin
        low = interleave ? (base ^ beat) : (base + beat);
        col = (base & ~wrap_mask) | (low & wrap_mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W  = 9,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              cmd_write,
    input  logic              cmd_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              vld;
        logic              last;
        logic              full;
        logic              inter;
        logic [COL_W-1:0]  mask;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  beat;
        logic [COL_W-1:0]  col;
    } state_t;

    state_t st_q, st_d;

    logic [COL_W-1:0] dec_mask_d;
    logic             dec_full_d;
    logic             dec_inter_d;
    logic [COL_W-1:0] beat_nxt_d;
    logic [COL_W-1:0] step_col_d;

    bcg_mode_dec #(.COL_W(COL_W), .MODE_W(MODE_W)) dec_i (
        .mode       (st_q.mode),
        .is_write   (cmd_write),
        .wrap_mask  (dec_mask_d),
        .full_page  (dec_full_d),
        .interleave (dec_inter_d)
    );

    assign beat_nxt_d = st_q.beat + COL_W'(1);

    bcg_col_calc #(.COL_W(COL_W)) calc_i (
        .base       (st_q.base),
        .beat       (beat_nxt_d),
        .wrap_mask  (st_q.mask),
        .interleave (st_q.inter),
        .col        (step_col_d)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_start) begin
            st_d.base  = start_col;
            st_d.beat  = '0;
            st_d.mask  = dec_mask_d;
            st_d.full  = dec_full_d;
            st_d.inter = dec_inter_d;
            st_d.col   = start_col;
            st_d.vld   = 1'b1;
            st_d.last  = !dec_full_d && (dec_mask_d == '0);
        end else if (cmd_stop) begin
            st_d.vld  = 1'b0;
            st_d.last = 1'b0;
        end else if (st_q.vld) begin
            if (st_q.last) begin
                st_d.vld  = 1'b0;
                st_d.last = 1'b0;
            end else begin
                st_d.beat = beat_nxt_d;
                st_d.col  = step_col_d;
                st_d.last = !st_q.full && (beat_nxt_d == st_q.mask);
            end
        end
        if (mode_load) begin
            st_d.mode = mode_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_addr  = st_q.col;
    assign col_valid = st_q.vld;
    assign col_last  = st_q.last;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic [COL_W-1:0] start_col,
    input logic             cmd_stop,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last
);
    // R3
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && col_addr == $past(start_col)));

    // R8
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !col_valid);

    // R3
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && !cmd_start) |=> !col_valid);

    // R3
    burst_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !cmd_start && !cmd_stop) |=> col_valid);

    // R1
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && !cmd_start) |=> !col_valid);
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .start_col (start_col),
    .cmd_stop  (cmd_stop),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [12:0] mode_word = '0;
    logic        cmd_start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        cmd_write = 1'b0;
    logic        cmd_stop = 1'b0;
    logic [8:0]  col_addr;
    logic        col_valid;
    logic        col_last;

    always #10 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_start(cmd_start), .start_col(start_col), .cmd_write(cmd_write),
        .cmd_stop(cmd_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [12:0] m_mode = '0;
    bit          m_vld = 0;
    int          m_base = 0, m_idx = 0, m_len = 1;
    bit          m_inter = 0;

    // length in beats, 0 meaning full page
    function automatic int ref_len(logic [12:0] md, bit wr);
        if (wr && md[9]) return 1;
        case (md[2:0])
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int ref_col(int base, int idx, int len, bit inter);
        int off, blk;
        if (len == 0) return (base + idx) % 512;
        off = base % len;
        blk = base - off;
        if (inter) return blk + (off ^ idx);
        return blk + ((off + idx) % len);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        bit exp_last;
        @(posedge clk);
        if (!rst_n) begin
            m_mode = '0; m_vld = 0;
        end else begin
            if (cmd_start) begin
                m_len   = ref_len(m_mode, cmd_write);
                m_inter = m_mode[3] && (m_len != 0);
                m_base  = int'(start_col);
                m_idx   = 0;
                m_vld   = 1;
            end else if (cmd_stop) begin
                m_vld = 0;
            end else if (m_vld) begin
                if (m_len != 0 && m_idx == m_len - 1) m_vld = 0;
                else m_idx++;
            end
            if (mode_load) m_mode = mode_word;
        end
        @(negedge clk);
        exp_last = m_vld && (m_len != 0) && (m_idx == m_len - 1);
        chk(col_valid == m_vld, cur_req, "valid", int'(col_valid), int'(m_vld));
        if (m_vld) begin
            chk(int'(col_addr) == ref_col(m_base, m_idx, m_len, m_inter), cur_req,
                "column", int'(col_addr), ref_col(m_base, m_idx, m_len, m_inter));
            chk(col_last == exp_last, cur_req, "last", int'(col_last), int'(exp_last));
        end
    endtask

    task automatic load(logic [12:0] m);
        mode_load = 1'b1; mode_word = m; cyc(); mode_load = 1'b0;
    endtask

    task automatic go(int c, bit wr);
        cmd_start = 1'b1; start_col = 9'(c); cmd_write = wr; cyc();
        cmd_start = 1'b0; cmd_write = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    int seq4[4] = '{1, 2, 3, 0};
    int seq8[8] = '{5, 4, 7, 6, 1, 0, 3, 2};

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state, then default mode gives a single beat
        cur_req = "R1";
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        chk(!col_valid && !col_last, "R1", "reset flags", int'({col_valid, col_last}), 0);
        go(37, 1'b0);
        chk(col_last && col_addr == 9'd37, "R1", "default single beat", int'(col_addr), 37);
        idle(2);

        // R2 and R4: sequential length 4 from column 1
        cur_req = "R4";
        load(13'b0_0000_0000_0010);
        go(1, 1'b0);
        chk(int'(col_addr) == seq4[0], "R2", "first beat", int'(col_addr), seq4[0]);
        for (int i = 1; i < 4; i++) begin
            cyc();
            chk(int'(col_addr) == seq4[i], "R4", "seq order", int'(col_addr), seq4[i]);
        end
        cyc();
        chk(!col_valid, "R3", "end after last", int'(col_valid), 0);

        // R5: interleaved length 8 from column 5
        cur_req = "R5";
        load(13'b0_0000_0000_1011);
        go(5, 1'b0);
        chk(int'(col_addr) == seq8[0], "R5", "xor order", int'(col_addr), seq8[0]);
        for (int i = 1; i < 8; i++) begin
            cyc();
            chk(int'(col_addr) == seq8[i], "R5", "xor order", int'(col_addr), seq8[i]);
        end
        idle(2);

        // R3, R4, R5: every start offset for lengths 2, 4, 8, both orders
        for (int o = 0; o < 2; o++) begin
            for (int lc = 1; lc < 4; lc++) begin
                cur_req = (o == 0) ? "R4" : "R5";
                load(13'(lc | (o << 3)));
                for (int s = 0; s < 16; s++) begin
                    go(s * 33, 1'b0);
                    idle(9);
                end
            end
        end

        // R6: full page with order bit set, wrap past 511, stop
        cur_req = "R6";
        load(13'b0_0000_0000_1111);
        go(500, 1'b0);
        idle(11);
        chk(int'(col_addr) == 511, "R6", "before wrap", int'(col_addr), 511);
        cyc();
        chk(int'(col_addr) == 0, "R6", "page wrap", int'(col_addr), 0);
        idle(600);
        chk(col_valid && !col_last, "R6", "still running", int'(col_valid), 1);
        cur_req = "R8";
        cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
        chk(!col_valid, "R8", "full page stop", int'(col_valid), 0);

        // R7: single-beat write option
        cur_req = "R7";
        load(13'b0_0010_0000_0010);
        go(8, 1'b1);
        chk(col_last, "R7", "write single beat", int'(col_last), 1);
        cyc();
        chk(!col_valid, "R7", "write ended", int'(col_valid), 0);
        go(8, 1'b0);
        idle(5);

        // R8: stop mid-burst, and start winning over stop
        cur_req = "R8";
        load(13'b0_0000_0000_0011);
        go(16, 1'b0);
        idle(2);
        cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
        chk(!col_valid, "R8", "stop length 8", int'(col_valid), 0);
        cmd_stop = 1'b1; go(40, 1'b0); cmd_stop = 1'b0;
        chk(col_valid && col_addr == 9'd40, "R8", "start beats stop", int'(col_addr), 40);
        idle(8);

        // R9: restart during a burst
        cur_req = "R9";
        go(0, 1'b0);
        idle(3);
        go(21, 1'b0);
        chk(int'(col_addr) == 21, "R9", "restart beat 0", int'(col_addr), 21);
        cyc();
        chk(int'(col_addr) == 22, "R9", "restart beat 1", int'(col_addr), 22);
        idle(8);

        // R10: reserved length codes act as length 1
        cur_req = "R10";
        for (int c = 4; c < 7; c++) begin
            load(13'(c));
            go(77, 1'b0);
            chk(col_last, "R10", "reserved single", int'(col_last), 1);
            cyc();
            chk(!col_valid, "R10", "reserved ended", int'(col_valid), 0);
        end

        // R11: mode load during a burst affects only later commands
        cur_req = "R11";
        load(13'b0_0000_0000_0011);
        go(3, 1'b0);
        idle(1);
        load(13'b0_0000_0000_1001);
        idle(5);
        chk(col_last && col_addr == 9'd2, "R11", "old burst kept", int'(col_addr), 2);
        go(3, 1'b0);
        cyc();
        chk(col_last && col_addr == 9'd2, "R11", "new length used", int'(col_addr), 2);
        idle(2);

        // random mix against the reference model
        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            cmd_start = ($urandom % 6) == 0;
            start_col = 9'($urandom);
            cmd_write = $urandom % 2;
            cmd_stop  = ($urandom % 20) == 0;
            mode_load = ($urandom % 25) == 0;
            mode_word = 13'($urandom) & 13'h020F;
            cyc();
        end
        cmd_start = 1'b0; cmd_stop = 1'b0; mode_load = 1'b0;
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule